// File: doc/BRIEF.md
# SDRAM Burst Data Path with Early Termination

This block is the device-side data path of a synchronous DRAM for burst transfers. Each clock it takes one decoded command (read, write, burst stop, precharge or no-op), together with a CAS-latency select, a burst-length code, a starting column and a write word. A shared burst engine walks the column counter through the burst and reads or writes a small internal word store. Read words leave through a data register and an output-enable, which together model a three-state bus. The output-enable is low when the bus is released.

The two paths end a burst at different times. On the read side, words that were already in flight keep coming out for the CAS latency after a stop. A precharge removes the youngest word one clock sooner. On the write side, a stop or precharge refuses the word offered in that same clock. No later word of the burst is taken either.

Data moves at times the commands fix, so neither edge has back-pressure. `wr_take` is the acceptance strobe for write data. The word on `wdata` is stored exactly in the cycles where `wr_take` is high. The source cannot stall the block, and the block cannot stall the source. Read words are valid exactly while `dq_oe` is high, and the receiver must take them in that cycle. The CAS-latency select may change only while no read word is in flight.

Top module: `sdram_burst_path`

## Requirements
- R1: After reset, `dq_oe` is low, `dq_out` is zero and `wr_take` is low while `cmd` is a no-op. The word store holds zero in every column.
- R2: `cmd` encodes no-op 0, read 1, write 2, burst stop 3 and precharge 4. A read captured at clock edge E puts its first word on the bus after edge E+CL, then one word after each following edge. CL is 2 when `cas3` is 0 and 3 when `cas3` is 1, sampled with the read.
- R3: `bl_code` 0, 1, 2, 3 gives bursts of 1, 2, 4 and 8 words. Code 7 gives full-page mode. The column starts at `col_start` and advances by one, wrapping inside the aligned block of burst-length words. In full-page mode the column wraps over the whole store and the burst runs until it is terminated.
- R4: A burst stop at edge S during a read lets the words fired at edges up to and including S appear. The bus is released from edge S+CL.
- R5: A precharge at edge S during a read drops the word that would have fired at S. The bus is released from edge S+CL-1.
- R6: A write at edge E stores `wdata` at `col_start` at that edge. The next words are stored at the following edges in the R3 column order, until the burst length is reached. `wr_take` is high in exactly those cycles.
- R7: A burst stop or precharge during a write stores nothing in its own cycle or later, and `wr_take` is low from that cycle on.
- R8: A burst stop or precharge with no burst active and no read word in flight has no effect. The bus stays released and no column is written.
- R9: A new read during a read burst still delivers the old burst's word fired at the new read's edge. The new burst follows with no gap on the bus.
- R10: `dq_out` is zero whenever `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Decoded command for this clock |
| cas3 | input | 1 | CAS latency select, 0 for 2 and 1 for 3 |
| bl_code | input | 3 | Burst length code |
| col_start | input | COL_W | Starting column of a read or write |
| wdata | input | DATA_W | Write word offered this clock |
| wr_take | output | 1 | High when `wdata` is stored this clock |
| dq_out | output | DATA_W | Read data register |
| dq_oe | output | 1 | Read bus drive enable |

## Verification
The hardest cases to reach from the ports are terminations that land on one chosen beat. Examples are a stop on the very edge that fires a read word, a precharge one clock after the read, or a stop deep inside a full-page burst that has already wrapped past the end of the store. The driver issues each command at a computed edge offset from the read or write that opened the burst. From the same offset it works out how many words must survive and on which edge each appears. The monitor then requires the bus to be released on the exact edge after the last expected word. Terminated writes are confirmed through later read bursts over the same columns.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_STOP  = 3'd3,
    CMD_PRECH = 3'd4
  } sdb_cmd_e;

  localparam logic [2:0] BLC_ONE  = 3'd0;
  localparam logic [2:0] BLC_TWO  = 3'd1;
  localparam logic [2:0] BLC_FOUR = 3'd2;
  localparam logic [2:0] BLC_EGHT = 3'd3;
  localparam logic [2:0] BLC_PAGE = 3'd7;
endpackage

// File: rtl/sdb_burst_ctrl.sv
module sdb_burst_ctrl
  import sdb_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd,
  input  logic [2:0]       bl_code,
  input  logic [COL_W-1:0] col_start,
  output logic             rd_fire,
  output logic             wr_en,
  output logic [COL_W-1:0] rd_col,
  output logic [COL_W-1:0] wr_col,
  output logic             burst_act
);
  logic             act_q, wr_q, full_q;
  logic [COL_W-1:0] col_q, idx_q, mask_q;
  logic [COL_W-1:0] new_mask;
  logic             new_full;
  logic             c_rd, c_wr, c_stop, c_pre, c_nop, last_beat;

  // Next column: low bits inside the burst window count and wrap, high bits hold.
  function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c,
                                                input logic [COL_W-1:0] m);
    return (c & ~m) | ((c + COL_W'(1)) & m);
  endfunction

  always_comb begin
    new_mask = '0;
    new_full = 1'b0;
    case (bl_code)
      BLC_TWO:  new_mask = COL_W'(1);
      BLC_FOUR: new_mask = COL_W'(3);
      BLC_EGHT: new_mask = COL_W'(7);
      BLC_PAGE: begin
        new_mask = '1;
        new_full = 1'b1;
      end
      default:  new_mask = '0;
    endcase
  end

  assign c_rd      = (cmd == CMD_READ);
  assign c_wr      = (cmd == CMD_WRITE);
  assign c_stop    = (cmd == CMD_STOP);
  assign c_pre     = (cmd == CMD_PRECH);
  assign c_nop     = !(c_rd || c_wr || c_stop || c_pre);
  assign last_beat = !full_q && (idx_q == mask_q);

  // Read beat leaves at this edge unless a precharge kills it at pipe entry.
  assign rd_fire   = act_q && !wr_q && !c_pre;
  // Write beat is taken only when nothing else claims the clock.
  assign wr_en     = c_wr || (act_q && wr_q && c_nop);
  assign wr_col    = c_wr ? col_start : col_q;
  assign rd_col    = col_q;
  assign burst_act = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      full_q <= 1'b0;
      col_q  <= '0;
      idx_q  <= '0;
      mask_q <= '0;
    end else if (c_rd) begin
      act_q  <= 1'b1;
      wr_q   <= 1'b0;
      col_q  <= col_start;
      idx_q  <= '0;
      mask_q <= new_mask;
      full_q <= new_full;
    end else if (c_wr) begin
      act_q  <= new_full || (new_mask != '0);
      wr_q   <= 1'b1;
      col_q  <= step_col(col_start, new_mask);
      idx_q  <= COL_W'(1);
      mask_q <= new_mask;
      full_q <= new_full;
    end else if (c_stop || c_pre) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      col_q <= step_col(col_q, mask_q);
      idx_q <= idx_q + COL_W'(1);
      if (last_beat) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sdb_word_store.sv
module sdb_word_store #(
  parameter int DATA_W = 16,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [COL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [COL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] row_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)                               row_q[g] <= '0;
      else if (we && (waddr == COL_W'(g)))      row_q[g] <= wdata;
    end
  end

  assign rdata = row_q[raddr];
endmodule

// File: rtl/sdb_rd_pipe.sv
module sdb_rd_pipe #(
  parameter int DATA_W = 16,
  parameter int CL_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cl3,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              any_vld
);
  localparam int DEPTH = CL_MAX;

  logic [DEPTH-1:0]  stg_v;
  logic [DATA_W-1:0] stg_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    if (g == 0) begin : g_head
      // An empty slot enters as a stop marker: invalid and zero data.
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else begin
          v_q <= in_vld;
          d_q <= in_vld ? in_data : '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else begin
          v_q <= stg_v[g-1];
          d_q <= stg_d[g-1];
        end
      end
    end
    assign stg_v[g] = v_q;
    assign stg_d[g] = d_q;
  end

  assign out_vld  = cl3 ? stg_v[DEPTH-1] : stg_v[DEPTH-2];
  assign out_data = cl3 ? stg_d[DEPTH-1] : stg_d[DEPTH-2];
  assign any_vld  = |stg_v;
endmodule

// File: rtl/sdram_burst_path.sv
module sdram_burst_path
  import sdb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic              cas3,
  input  logic [2:0]        bl_code,
  input  logic [COL_W-1:0]  col_start,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_take,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int CL_MAX = 3;

  logic              rd_fire, wr_en, burst_act, pipe_any, cl3_q;
  logic [COL_W-1:0]  rd_col, wr_col;
  logic [DATA_W-1:0] rd_word;

  // Latency is taken with each read and held for its words.
  always_ff @(posedge clk) begin
    if (!rst_n)                 cl3_q <= 1'b0;
    else if (cmd == CMD_READ)   cl3_q <= cas3;
  end

  sdb_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .bl_code   (bl_code),
    .col_start (col_start),
    .rd_fire   (rd_fire),
    .wr_en     (wr_en),
    .rd_col    (rd_col),
    .wr_col    (wr_col),
    .burst_act (burst_act)
  );

  sdb_word_store #(.DATA_W(DATA_W), .COL_W(COL_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_col),
    .wdata (wdata),
    .raddr (rd_col),
    .rdata (rd_word)
  );

  sdb_rd_pipe #(.DATA_W(DATA_W), .CL_MAX(CL_MAX)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (rd_fire),
    .in_data  (rd_word),
    .cl3      (cl3_q),
    .out_vld  (dq_oe),
    .out_data (dq_out),
    .any_vld  (pipe_any)
  );

  assign wr_take = wr_en;
endmodule

// File: rtl/sdram_burst_path_chk.sv
module sdram_burst_path_chk
  import sdb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic              cas3,
  input logic              cl3_q,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out,
  input logic              wr_take,
  input logic              burst_act,
  input logic              pipe_any
);
  // R2
  rd_first_cl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ && !cas3) ##1 (cmd == CMD_NOP || cmd == CMD_STOP)
      ##1 (cmd != CMD_READ) |=> dq_oe);

  // R2
  rd_first_cl3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ && cas3) ##1 (cmd == CMD_NOP || cmd == CMD_STOP)
      ##1 (cmd != CMD_READ) ##1 (cmd != CMD_READ) |=> dq_oe);

  // R4
  rd_stop_cl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP && !cl3_q) ##1 (cmd != CMD_READ) ##1 (cmd != CMD_READ) |=> !dq_oe);

  // R4
  rd_stop_cl3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP && cl3_q) ##1 (cmd != CMD_READ) ##1 (cmd != CMD_READ)
      ##1 (cmd != CMD_READ) |=> !dq_oe);

  // R5
  rd_prech_cl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRECH && !cl3_q) ##1 (cmd != CMD_READ) |=> !dq_oe);

  // R5
  rd_prech_cl3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRECH && cl3_q) ##1 (cmd != CMD_READ) ##1 (cmd != CMD_READ) |=> !dq_oe);

  // R7
  wr_refuse_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP || cmd == CMD_PRECH) |-> !wr_take);

  // R7
  wr_refuse_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP || cmd == CMD_PRECH) ##1 (cmd == CMD_NOP) |-> !wr_take);

  // R8
  idle_stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_STOP || cmd == CMD_PRECH) && !burst_act && !pipe_any) |=> !dq_oe);

  // R10
  bus_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));
endmodule

bind sdram_burst_path sdram_burst_path_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd       (cmd),
  .cas3      (cas3),
  .cl3_q     (cl3_q),
  .dq_oe     (dq_oe),
  .dq_out    (dq_out),
  .wr_take   (wr_take),
  .burst_act (burst_act),
  .pipe_any  (pipe_any)
);

// File: tb/sdram_burst_path_bench.sv
module sdram_burst_path_bench;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int T_NONE = 0, T_READ = 1, T_STOP = 3, T_PRE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd = 3'd0;
  logic          cas3 = 1'b0;
  logic [2:0]    bl_code = 3'd0;
  logic [CW-1:0] col_start = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr_take;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  sdram_burst_path #(.DATA_W(DW), .COL_W(CW)) u_sdram_burst_path (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cas3(cas3), .bl_code(bl_code),
    .col_start(col_start), .wdata(wdata), .wr_take(wr_take),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #5 clk = ~clk;

  typedef struct { int at; logic [DW-1:0] d; string req; } exp_t;
  exp_t          sb_q[$];
  logic [DW-1:0] ref_mem [1 << CW];
  int            cyc = 0;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            mon_on = 1'b0;
  bit            done = 1'b0;
  string         zreq = "R1";

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at edge %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  function automatic int bl_len(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 1 << CW;
      default: return 1;
    endcase
  endfunction

  function automatic int nxt(input int c, input int len);
    return (c & ~(len - 1)) | ((c + 1) & (len - 1));
  endfunction

  // Monitor: pops expected words on their edge, else demands a released bus.
  always @(negedge clk) begin
    if (mon_on) begin
      while (sb_q.size() > 0 && sb_q[0].at < cyc) begin
        check(1'b0, sb_q[0].req, "missing read word", '0, sb_q[0].d);
        void'(sb_q.pop_front());
      end
      if (sb_q.size() > 0 && sb_q[0].at == cyc) begin
        check(dq_oe === 1'b1 && dq_out === sb_q[0].d, sb_q[0].req, "read word",
              dq_oe ? dq_out : 'x, sb_q[0].d);
        void'(sb_q.pop_front());
      end else begin
        check(dq_oe === 1'b0, zreq, "bus should be released", {15'd0, dq_oe}, '0);
        if (dq_oe === 1'b0) check(dq_out === '0, "R10", "idle data not zero", dq_out, '0);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cmd = 3'd0;
    end
  endtask

  // Read burst; term issued at edge offset k (T_READ: next call issues it).
  task automatic rd_burst(input int start, input int code, input bit c3,
                          input int k, input int term, input string tag);
    int len, cap, nb, p0, c;
    len = bl_len(code);
    cap = (code == 7) ? 100000 : len;
    @(negedge clk);
    cmd = 3'd1; bl_code = 3'(code); cas3 = c3; col_start = CW'(start);
    p0 = cyc + 1;
    zreq = tag;
    nb = cap;
    if ((term == T_STOP || term == T_READ) && k < nb) nb = k;
    if (term == T_PRE && (k - 1) < nb) nb = k - 1;
    c = start;
    for (int j = 0; j < nb; j++) begin
      sb_q.push_back('{p0 + j + (c3 ? 3 : 2), ref_mem[c], tag});
      c = nxt(c, len);
    end
    for (int i = 1; i < k; i++) begin
      @(negedge clk);
      cmd = 3'd0;
    end
    if (term == T_STOP || term == T_PRE) begin
      @(negedge clk);
      cmd = 3'(term);
    end
  endtask

  // Write burst with data base+j on beat j; term issued at offset k.
  task automatic wr_burst(input int start, input int code, input int k,
                          input int term, input int base, input string tag);
    int len, cap, nb, last, c;
    len = bl_len(code);
    cap = (code == 7) ? 100000 : len;
    nb = (term == T_NONE) ? cap : ((k < cap) ? k : cap);
    last = (term == T_NONE) ? len : k;
    c = start;
    for (int j = 0; j <= last; j++) begin
      @(negedge clk);
      if (j == 0)                              cmd = 3'd2;
      else if (j == k && term != T_NONE)       cmd = 3'(term);
      else                                     cmd = 3'd0;
      bl_code = 3'(code); col_start = CW'(start); wdata = DW'(base + j);
      #1;
      check(wr_take === (j < nb), tag, "write accept strobe", {15'd0, wr_take}, {15'd0, (j < nb)});
      if (j < nb) begin
        ref_mem[c] = DW'(base + j);
        c = nxt(c, len);
      end
    end
    @(negedge clk);
    cmd = 3'd0;
  endtask

  initial begin
    for (int i = 0; i < (1 << CW); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dq_oe === 1'b0, "R1", "oe in reset", {15'd0, dq_oe}, '0);
    check(wr_take === 1'b0, "R1", "take in reset", {15'd0, wr_take}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dq_out === '0, "R1", "data after reset", dq_out, '0);
    mon_on = 1'b1;
    idle(2);
    // R1: store starts at zero
    rd_burst(0, 3, 1'b0, 8, T_NONE, "R1");
    idle(5);

    // R6 and R3: full-page write of all columns, stopped after 16 words
    wr_burst(0, 7, 16, T_STOP, 16'h1100, "R6");
    idle(2);
    // R2 / R3: plain reads, both latencies, wrap inside the window
    rd_burst(2, 2, 1'b0, 4, T_NONE, "R2");
    idle(5);
    rd_burst(6, 2, 1'b1, 4, T_NONE, "R3");
    idle(5);
    rd_burst(5, 3, 1'b1, 8, T_NONE, "R3");
    idle(5);
    rd_burst(3, 1, 1'b0, 2, T_NONE, "R3");
    idle(5);
    rd_burst(9, 0, 1'b1, 1, T_NONE, "R3");
    idle(5);

    // R4: burst stop on reads
    rd_burst(0, 3, 1'b0, 3, T_STOP, "R4");
    idle(5);
    rd_burst(4, 3, 1'b1, 2, T_STOP, "R4");
    idle(5);
    rd_burst(8, 2, 1'b1, 1, T_STOP, "R4");
    idle(5);
    // R5: precharge on reads
    rd_burst(1, 3, 1'b0, 3, T_PRE, "R5");
    idle(5);
    rd_burst(10, 3, 1'b1, 3, T_PRE, "R5");
    idle(5);
    rd_burst(12, 2, 1'b0, 1, T_PRE, "R5");
    idle(5);
    // R3: full page read wrapping past the end, stopped after 20 words
    rd_burst(9, 7, 1'b1, 20, T_STOP, "R3");
    idle(5);

    // R7: terminated writes, then read back
    wr_burst(8, 3, 3, T_STOP, 16'h2200, "R7");
    wr_burst(12, 2, 2, T_PRE, 16'h3300, "R7");
    rd_burst(8, 3, 1'b0, 8, T_NONE, "R7");
    idle(5);
    // R6: short write completes by itself
    wr_burst(1, 1, 0, T_NONE, 16'h4400, "R6");
    rd_burst(0, 2, 1'b1, 4, T_NONE, "R6");
    idle(5);

    // R8: stop and precharge while idle
    zreq = "R8";
    @(negedge clk);
    cmd = 3'd3; wdata = 16'hdead; col_start = 4'd8;
    #1 check(wr_take === 1'b0, "R8", "idle stop take", {15'd0, wr_take}, '0);
    @(negedge clk);
    cmd = 3'd4;
    #1 check(wr_take === 1'b0, "R8", "idle precharge take", {15'd0, wr_take}, '0);
    idle(5);
    rd_burst(8, 3, 1'b1, 8, T_NONE, "R8");
    idle(5);

    // R9: back-to-back reads
    rd_burst(0, 3, 1'b0, 3, T_READ, "R9");
    rd_burst(4, 2, 1'b0, 4, T_NONE, "R9");
    idle(6);

    check(sb_q.size() == 0, "R2", "words left unseen", DW'(sb_q.size()), '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at edge %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule